// File: doc/BRIEF.md
# Reset Sequencer with Source Detection

The reset sequencer turns any reset request into a fixed-length low pulse on a shared, open-drain reset pin. It then lets the pin go, waits a fixed settling time, and reads the pin back. A pin still held low at that point means something outside the chip is holding reset, so the reset is classed as external. Otherwise the block picks a vector class from the internal causes it has latched. The processor uses the resulting 2-bit class to choose its reset vector in the single fetch cycle that follows.

Several internal requests feed the block: power-on, low-voltage, illegal address, watchdog timeout and clock-monitor failure. It also watches the synchronized pin level, so an external agent pulling the pin low while the chip runs starts the same sequence. Power-on acts asynchronously. It forces the block into the pulse phase with every pending cause cleared, and it holds it there for as long as it is asserted.

Top module: `reset_sequencer`

## Requirements
- R1: A reset request drives `pinPullDown` high for exactly 512 clock cycles. A further request that arrives during this pulse neither shortens nor lengthens it.
- R2: After the pulse, `pinPullDown` falls and `sysReset` stays high for 256 more cycles, 768 cycles in all. `sysReset` then falls and `fetchStrobe` is high for exactly one cycle.
- R3: If the synchronized pin is low at the end of the 256-cycle wait, `vecSel` becomes 2'b11 (external), whatever causes are pending.
- R4: If the pin is high and a clock-monitor failure is pending, `vecSel` becomes 2'b01. This takes priority over a pending watchdog timeout.
- R5: If the pin is high, no clock-monitor failure is pending and a watchdog timeout is pending, `vecSel` becomes 2'b10.
- R6: If the pin is high and neither cause is pending, `vecSel` becomes 2'b00. This class covers power-on, low-voltage and illegal-address resets.
- R7: A watchdog or clock-monitor request sets a sticky pending cause, even when it arrives in the middle of a sequence. A cause is cleared only by the fetch cycle or by `porReq`.
- R8: An internal request during the 256-cycle wait aborts the wait and starts a complete new 512-cycle pulse.
- R9: While the block is idle, a low level on `pinSense` starts a sequence once it has passed a two-flop synchronizer.
- R10: `vecSel` holds its value from one fetch cycle to the next. While `porReq` is high, `pinPullDown` and `sysReset` are high, `fetchStrobe` is low and `vecSel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reset-time clock |
| porReq | input | 1 | Power-on request, active high, asynchronous |
| lvdReq | input | 1 | Low-voltage request |
| illAddrReq | input | 1 | Illegal-address request |
| wdogReq | input | 1 | Watchdog timeout request |
| clkMonReq | input | 1 | Clock-monitor failure request |
| pinSense | input | 1 | Level sensed on the reset pin |
| pinPullDown | output | 1 | Enable for the pin's pull-down driver |
| sysReset | output | 1 | Internal system reset |
| fetchStrobe | output | 1 | One-cycle vector-fetch marker |
| vecSel | output | 2 | Selected vector class |

## Verification
A wrong count or phase state shows at once on `pinPullDown` or `sysReset` as a pulse or wait that is not 512 or 256 cycles long, and the error is visible no later than the following fetch. A pending cause that is lost, or one that survives when it should be cleared, stays hidden until the next fetch cycle. At that point `vecSel` shows the wrong class, so the bench runs back-to-back sequences whose expected classes differ. A fault in the pin synchronizer shows as an external reset that is missed or a spurious restart, both within a few cycles of the sampling edge.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    VEC_POWER  = 2'b00,
    VEC_CLKMON = 2'b01,
    VEC_WDOG   = 2'b10,
    VEC_PIN    = 2'b11
  } vecClass_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_FETCH
  } seqState_e;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic cntClear;
    logic loadVec;
    logic clearFlags;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int PULSE_CYCLES = 512,
  parameter int WAIT_CYCLES  = 256
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       lvdReq,
  input  logic       illAddrReq,
  input  logic       wdogReq,
  input  logic       clkMonReq,
  input  logic       pinSense,
  input  seqStrobe_t strobe,
  output logic       pulseDone,
  output logic       waitDone,
  output logic       pinLowSync,
  output logic       intReq,
  output vecClass_e  vecSel
);

  localparam int MAX_CYCLES = (PULSE_CYCLES > WAIT_CYCLES) ? PULSE_CYCLES : WAIT_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  logic [CNT_W-1:0] phaseCnt;
  logic [1:0]       syncQ;
  logic             wdogPend;
  logic             clkMonPend;

  // phase counter shared by pulse and wait
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)               phaseCnt <= '0;
    else if (strobe.cntClear) phaseCnt <= '0;
    else                      phaseCnt <= phaseCnt + 1'b1;
  end

  assign pulseDone = (phaseCnt == CNT_W'(PULSE_CYCLES - 1));
  assign waitDone  = (phaseCnt == CNT_W'(WAIT_CYCLES - 1));

  // two-flop synchronizer on the pin; idle level is high
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) syncQ <= 2'b11;
    else        syncQ <= {syncQ[0], pinSense};
  end

  assign pinLowSync = ~syncQ[1];
  assign intReq     = lvdReq | illAddrReq | wdogReq | clkMonReq;

  // sticky causes: a new request wins over clearing
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      wdogPend   <= 1'b0;
      clkMonPend <= 1'b0;
    end else begin
      wdogPend   <= wdogReq   | (wdogPend   & ~strobe.clearFlags);
      clkMonPend <= clkMonReq | (clkMonPend & ~strobe.clearFlags);
    end
  end

  // vector class, priority: pin, clock monitor, watchdog, power
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) vecSel <= VEC_POWER;
    else if (strobe.loadVec) begin
      if (pinLowSync)      vecSel <= VEC_PIN;
      else if (clkMonPend) vecSel <= VEC_CLKMON;
      else if (wdogPend)   vecSel <= VEC_WDOG;
      else                 vecSel <= VEC_POWER;
    end
  end

  // R10: the class changes only when a selection is loaded
  a_r10_vec_hold: assert property (@(posedge clk) disable iff (porReq)
    !strobe.loadVec |=> $stable(vecSel));

  // R7: a pending cause survives until a clearing strobe
  a_r7_wdog_sticky: assert property (@(posedge clk) disable iff (porReq)
    (wdogPend && !strobe.clearFlags) |=> wdogPend);

  a_r7_clkmon_sticky: assert property (@(posedge clk) disable iff (porReq)
    (clkMonPend && !strobe.clearFlags) |=> clkMonPend);

  // R3: a low pin at the sampling edge always yields the external class
  a_r3_pin_wins: assert property (@(posedge clk) disable iff (porReq)
    (strobe.loadVec && pinLowSync) |=> (vecSel == VEC_PIN));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porReq,
  input  logic       pulseDone,
  input  logic       waitDone,
  input  logic       pinLowSync,
  input  logic       intReq,
  output seqStrobe_t strobe,
  output logic       pinPullDown,
  output logic       sysReset,
  output logic       fetchStrobe
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) state <= ST_PULSE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (intReq || pinLowSync) begin
          stateNext       = ST_PULSE;
          strobe.cntClear = 1'b1;
        end
      end
      ST_PULSE: begin
        // requests in this phase do not touch the count
        if (pulseDone) begin
          stateNext       = ST_WAIT;
          strobe.cntClear = 1'b1;
        end
      end
      ST_WAIT: begin
        if (intReq) begin
          stateNext       = ST_PULSE;
          strobe.cntClear = 1'b1;
        end else if (waitDone) begin
          stateNext      = ST_FETCH;
          strobe.loadVec = 1'b1;
        end
      end
      ST_FETCH: begin
        strobe.clearFlags = 1'b1;
        if (intReq) begin
          stateNext       = ST_PULSE;
          strobe.cntClear = 1'b1;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign pinPullDown = (state == ST_PULSE);
  assign sysReset    = (state == ST_PULSE) || (state == ST_WAIT);
  assign fetchStrobe = (state == ST_FETCH);

  // R1: the pulse keeps running until the counter reports its end
  a_r1_pulse_holds: assert property (@(posedge clk) disable iff (porReq)
    (pinPullDown && !pulseDone) |=> pinPullDown);

  // R2: the pulse end always leads into the wait, with reset still held
  a_r2_wait_after_pulse: assert property (@(posedge clk) disable iff (porReq)
    (pinPullDown && pulseDone) |=> (sysReset && !pinPullDown));

  // R2: the fetch cycle lasts one cycle
  a_r2_fetch_single: assert property (@(posedge clk) disable iff (porReq)
    fetchStrobe |=> !fetchStrobe);

  // R8: a request during the wait restarts the pulse
  a_r8_wait_restart: assert property (@(posedge clk) disable iff (porReq)
    (sysReset && !pinPullDown && intReq) |=> pinPullDown);

  // R9: a low synchronized pin while idle starts a sequence
  a_r9_pin_start: assert property (@(posedge clk) disable iff (porReq)
    (!sysReset && !fetchStrobe && pinLowSync) |=> pinPullDown);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int PULSE_CYCLES = 512,
  parameter int WAIT_CYCLES  = 256
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       lvdReq,
  input  logic       illAddrReq,
  input  logic       wdogReq,
  input  logic       clkMonReq,
  input  logic       pinSense,
  output logic       pinPullDown,
  output logic       sysReset,
  output logic       fetchStrobe,
  output logic [1:0] vecSel
);

  seqStrobe_t strobe;
  logic       pulseDone;
  logic       waitDone;
  logic       pinLowSync;
  logic       intReq;
  vecClass_e  vecClass;

  rst_seq_ctrl u_ctrl (
    .clk         (clk),
    .porReq      (porReq),
    .pulseDone   (pulseDone),
    .waitDone    (waitDone),
    .pinLowSync  (pinLowSync),
    .intReq      (intReq),
    .strobe      (strobe),
    .pinPullDown (pinPullDown),
    .sysReset    (sysReset),
    .fetchStrobe (fetchStrobe)
  );

  rst_seq_dp #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .WAIT_CYCLES  (WAIT_CYCLES)
  ) u_dp (
    .clk        (clk),
    .porReq     (porReq),
    .lvdReq     (lvdReq),
    .illAddrReq (illAddrReq),
    .wdogReq    (wdogReq),
    .clkMonReq  (clkMonReq),
    .pinSense   (pinSense),
    .strobe     (strobe),
    .pulseDone  (pulseDone),
    .waitDone   (waitDone),
    .pinLowSync (pinLowSync),
    .intReq     (intReq),
    .vecSel     (vecClass)
  );

  assign vecSel = vecClass;

endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;

  logic       clk = 1'b0;
  logic       porReq = 1'b1;
  logic       lvdReq = 1'b0;
  logic       illAddrReq = 1'b0;
  logic       wdogReq = 1'b0;
  logic       clkMonReq = 1'b0;
  logic       extLow = 1'b0;
  logic       pinSense;
  logic       pinPullDown;
  logic       sysReset;
  logic       fetchStrobe;
  logic [1:0] vecSel;

  int checks = 0;
  int failures = 0;
  int fetchSeen = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] vec;
    bit         chkLen;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [1:0] lastVec = 2'b00;

  always #10 clk = ~clk;

  // open-drain pin: low if the block or an outside agent pulls it
  assign pinSense = ~(pinPullDown | extLow);

  reset_sequencer u_reset_sequencer (
    .clk         (clk),
    .porReq      (porReq),
    .lvdReq      (lvdReq),
    .illAddrReq  (illAddrReq),
    .wdogReq     (wdogReq),
    .clkMonReq   (clkMonReq),
    .pinSense    (pinSense),
    .pinPullDown (pinPullDown),
    .sysReset    (sysReset),
    .fetchStrobe (fetchStrobe),
    .vecSel      (vecSel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic skipCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(input logic [1:0] v, input bit chkLen, input string tag);
    expItem_t it;
    it.vec = v;
    it.chkLen = chkLen;
    it.tag = tag;
    expQ.push_back(it);
    lastVec = v;
  endtask

  // one-cycle internal request: 0 lvd, 1 illegal addr, 2 wdog, 3 clkmon
  task automatic pulseReq(input int which);
    @(negedge clk);
    case (which)
      0: lvdReq = 1'b1;
      1: illAddrReq = 1'b1;
      2: wdogReq = 1'b1;
      default: clkMonReq = 1'b1;
    endcase
    @(negedge clk);
    lvdReq = 1'b0;
    illAddrReq = 1'b0;
    wdogReq = 1'b0;
    clkMonReq = 1'b0;
  endtask

  // wait for the fetch that matches all queued expectations, then check the hold
  task automatic finishSeq(input string tag);
    int target;
    target = fetchSeen + expQ.size();
    while (fetchSeen < target) @(negedge clk);
    skipCycles(12);
    check(vecSel == lastVec, {"R10 hold ", tag}, vecSel, lastVec);
    check(!sysReset && !pinPullDown, {"R2 idle after ", tag}, sysReset, 0);
  endtask

  // monitor: measure phases and score each fetch against the queue
  int  pulseRun = 0;
  int  waitRun = 0;
  int  lastPulse = 0;
  bit  prevPull = 1'b0;

  always @(negedge clk) begin
    if (pinPullDown) begin
      if (!prevPull) begin
        pulseRun = 0;
        waitRun = 0;
      end
      pulseRun++;
    end else begin
      if (prevPull) lastPulse = pulseRun;
      if (sysReset) waitRun++;
    end
    prevPull = pinPullDown;
    if (fetchStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected fetch", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(vecSel == it.vec, {"vector ", it.tag}, vecSel, it.vec);
        check(!sysReset, {"R2 reset low at fetch ", it.tag}, sysReset, 0);
        if (it.chkLen) begin
          check(lastPulse == 512, {"R1 pulse length ", it.tag}, lastPulse, 512);
          check(waitRun == 256, {"R2 wait length ", it.tag}, waitRun, 256);
        end
      end
      fetchSeen++;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: state while power-on is held
    skipCycles(3);
    check(pinPullDown == 1'b1, "R10 por pulldown", pinPullDown, 1);
    check(sysReset == 1'b1, "R10 por sysReset", sysReset, 1);
    check(fetchStrobe == 1'b0, "R10 por fetch", fetchStrobe, 0);
    check(vecSel == 2'b00, "R10 por vecSel", vecSel, 0);
    pushExp(2'b00, 1'b0, "R6 power-on");
    porReq = 1'b0;
    finishSeq("por");

    // R6, R1, R2: low-voltage
    pushExp(2'b00, 1'b1, "R6 low-voltage");
    pulseReq(0);
    finishSeq("lvd");

    // R5: watchdog
    pushExp(2'b10, 1'b1, "R5 watchdog");
    pulseReq(2);
    finishSeq("wdog");

    // R4: clock monitor
    pushExp(2'b01, 1'b1, "R4 clock monitor");
    pulseReq(3);
    finishSeq("clkmon");

    // R4: clock monitor outranks watchdog
    pushExp(2'b01, 1'b1, "R4 priority over watchdog");
    @(negedge clk);
    wdogReq = 1'b1;
    clkMonReq = 1'b1;
    @(negedge clk);
    wdogReq = 1'b0;
    clkMonReq = 1'b0;
    finishSeq("both");

    // R7, R6: previous causes were cleared by the fetch
    pushExp(2'b00, 1'b1, "R7 cleared then R6 illegal address");
    pulseReq(1);
    finishSeq("illaddr");

    // R1, R7: requests inside the pulse: no length change, cause latched
    pushExp(2'b01, 1'b1, "R1 R7 request during pulse");
    pulseReq(0);
    skipCycles(200);
    pulseReq(3);
    finishSeq("midpulse");

    // R8: request in the wait restarts a full pulse
    pushExp(2'b10, 1'b1, "R8 restart in wait");
    @(negedge clk);
    lvdReq = 1'b1;
    @(negedge clk);
    lvdReq = 1'b0;
    skipCycles(610);
    check(sysReset && !pinPullDown, "R8 in wait before restart", pinPullDown, 0);
    wdogReq = 1'b1;
    @(negedge clk);
    wdogReq = 1'b0;
    check(pinPullDown == 1'b1, "R8 pulse restarted", pinPullDown, 1);
    finishSeq("restart");

    // R9, R3: outside agent pulls the pin while idle, holds through sampling
    pushExp(2'b11, 1'b1, "R9 R3 external pin");
    @(negedge clk);
    extLow = 1'b1;
    skipCycles(2);
    check(!sysReset, "R9 synchronizer delay", sysReset, 0);
    skipCycles(767);
    extLow = 1'b0;
    finishSeq("extpin");

    // R3: pin low at sampling beats a pending watchdog
    pushExp(2'b11, 1'b1, "R3 pin beats watchdog");
    @(negedge clk);
    wdogReq = 1'b1;
    @(negedge clk);
    wdogReq = 1'b0;
    skipCycles(599);
    extLow = 1'b1;
    skipCycles(167);
    extLow = 1'b0;
    finishSeq("extwdog");

    // R7: watchdog cause was consumed by that fetch
    pushExp(2'b00, 1'b1, "R7 watchdog cleared");
    pulseReq(0);
    finishSeq("afterext");

    // R7: power-on clears a pending watchdog cause mid-sequence
    pushExp(2'b00, 1'b0, "R7 por clears cause");
    pulseReq(2);
    skipCycles(100);
    porReq = 1'b1;
    skipCycles(5);
    check(vecSel == 2'b00, "R10 por forces class", vecSel, 0);
    porReq = 1'b0;
    finishSeq("porclear");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule